// File: doc/BRIEF.md
# I2C Slave Controller with Masked Address Match

This block is the target side of an I2C link. It watches the clock and data lines through synchronisers, recognises Start and Stop conditions, and shifts in an address byte. It compares that byte with a programmable 7-bit own address. A second 7-bit register selects which address bits take part in the compare, so one device can answer a whole group of addresses. On a match it acknowledges in the ninth clock. The R/W bit then decides whether the bytes that follow are received or transmitted.

Received bytes collect in a shift register. When a byte is complete it is copied into a holding buffer, and a full flag and an interrupt flag are set. Software therefore has a full byte time to read the buffer before the next byte lands. If a byte completes while the buffer is still unread, the byte is refused with a NACK and an overflow flag is set. Transmission is single-buffered: a software write to the data register loads the holding buffer and the shift register at the same time.

Start and Stop flags in the status register show whether the bus is busy or free. Access from software goes through a small register port with four registers: own address, mask, data and status.

Top module: `i2cs_slave`

## Requirements
- R1: After reset, register 0 (own address) reads 0x00, register 1 (mask) reads 0x7F, register 2 (data) reads 0x00 and register 3 (status) reads 0x00. The SDA pull-down and `irq_o` are inactive.
- R2: A Start (SDA falling while SCL is high) sets status bit 5 and clears bit 4. A Stop (SDA rising while SCL is high) sets bit 4 and clears bit 5. The two bits are never set together.
- R3: The address byte is sent MSB first, with R/W as its eighth bit. The slave acknowledges it by pulling SDA low during the ninth clock if and only if `((addr ^ own) & mask) == 0`. Mask bits at 0 are don't-care. A match sets status bit 2.
- R4: When the address does not match, the slave leaves SDA released, and the bytes that follow, up to the next Start, are neither acknowledged nor stored.
- R5: While status bit 7 is set, address 0x00 with R/W = 0 (general call) is acknowledged whatever the own address and mask are. While bit 7 is clear it is not.
- R6: In receive mode, each completed byte is copied to the data register. Status bits 1 (full) and 0 (interrupt) are set, `irq_o` is raised, and the byte is acknowledged. Reading register 2 returns the byte and clears bits 1 and 0.
- R7: If a byte completes while status bit 1 is still set, status bit 6 (overflow) is set, the data register keeps its old value, and the byte is not acknowledged.
- R8: On an address match with R/W = 1, status bit 3 and the interrupt flag are set. A write to register 2 loads the byte to send and clears the interrupt. The slave drives that byte MSB first, one bit per clock. Each byte the master acknowledges sets the interrupt again.
- R9: In transmit mode, a master NACK ends the transfer. SDA stays released until the next Start.
- R10: Status bits 7 and 6 can be written. A write to status has no effect on bits 5 to 0.
- R11: The SDA pull-down only switches on while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_sel_i | input | 2 | Register select: 0 own address, 1 mask, 2 data, 3 status |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (read side effects) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, selected by reg_sel_i |
| irq_o | output | 1 | Interrupt flag (status bit 0) |

## Verification
The assertions assume the following about the inputs:
- SCL and SDA stay stable for several system clocks between changes, longer than the synchroniser depth.
- The master moves SDA only while SCL is low, except when it makes a Start or a Stop.
- Software does not write the data register in the same cycle that a byte boundary is detected.

The stimulus keeps within these limits. Every bus phase lasts ten system clocks. Data changes are placed well inside the low half of SCL. Software writes for transmit data are issued in the middle of the acknowledge clock, away from any edge the slave reacts to.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } state_e;

  localparam logic [1:0] SEL_OWN  = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int STAT_GCEN = 7;
  localparam int STAT_OVF  = 6;
  localparam int STAT_S    = 5;
  localparam int STAT_P    = 4;
  localparam int STAT_XMIT = 3;
  localparam int STAT_HIT  = 2;
  localparam int STAT_FULL = 1;
  localparam int STAT_IRQ  = 0;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  // idle bus level is high, so reset to ones to avoid a false Start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2cs_cond_det.sv
module i2cs_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_i;
  assign scl_fall_o = scl_q && !scl_i;
  assign start_o    = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o     = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/i2cs_addr_cmp.sv
module i2cs_addr_cmp #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] rx_addr_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] own_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              gc_en_i,
  output logic              hit_o
);
  logic own_hit, gc_hit;

  assign own_hit = ((rx_addr_i ^ own_i) & mask_i) == '0;
  assign gc_hit  = gc_en_i && (rx_addr_i == '0) && !rw_i;
  assign hit_o   = own_hit || gc_hit;
endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave
  import i2cs_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [1:0]        reg_sel_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic addr_hit;

  state_e            state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sr_q, buf_q;
  logic [ADDR_W-1:0] own_q, mask_q;
  logic gc_en_q, ovf_q, s_q, p_q, xmit_q, hit_q, full_q, irq_q, mack_q;

  i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i2cs_cond_det u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_ev),
    .stop_o    (stop_ev)
  );

  i2cs_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .rx_addr_i(sr_q[DATA_W-1 -: ADDR_W]),
    .rw_i     (sr_q[0]),
    .own_i    (own_q),
    .mask_i   (mask_q),
    .gc_en_i  (gc_en_q),
    .hit_o    (addr_hit)
  );

  logic data_wr, data_rd, stat_wr;
  assign data_wr = reg_we_i && reg_sel_i == SEL_DATA;
  assign data_rd = reg_re_i && reg_sel_i == SEL_DATA;
  assign stat_wr = reg_we_i && reg_sel_i == SEL_STAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q   <= '0;
      mask_q  <= '1;
      gc_en_q <= 1'b0;
    end else if (reg_we_i) begin
      if (reg_sel_i == SEL_OWN)  own_q   <= reg_wdata_i[ADDR_W-1:0];
      if (reg_sel_i == SEL_MASK) mask_q  <= reg_wdata_i[ADDR_W-1:0];
      if (reg_sel_i == SEL_STAT) gc_en_q <= reg_wdata_i[STAT_GCEN];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sr_q       <= '0;
      buf_q      <= '0;
      sda_pull_o <= 1'b0;
      ovf_q      <= 1'b0;
      s_q        <= 1'b0;
      p_q        <= 1'b0;
      xmit_q     <= 1'b0;
      hit_q      <= 1'b0;
      full_q     <= 1'b0;
      irq_q      <= 1'b0;
      mack_q     <= 1'b0;
    end else begin
      if (data_wr) begin
        buf_q <= reg_wdata_i;
        sr_q  <= reg_wdata_i;
        irq_q <= 1'b0;
      end
      if (data_rd) begin
        full_q <= 1'b0;
        irq_q  <= 1'b0;
      end
      if (stat_wr) ovf_q <= reg_wdata_i[STAT_OVF];

      if (start_ev) begin
        state_q    <= ST_ADDR;
        cnt_q      <= '0;
        sda_pull_o <= 1'b0;
        s_q        <= 1'b1;
        p_q        <= 1'b0;
        xmit_q     <= 1'b0;
        hit_q      <= 1'b0;
      end else if (stop_ev) begin
        state_q    <= ST_IDLE;
        sda_pull_o <= 1'b0;
        s_q        <= 1'b0;
        p_q        <= 1'b1;
        xmit_q     <= 1'b0;
        hit_q      <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_RX: begin
            if (scl_rise && cnt_q != CNT_FULL) begin
              sr_q  <= {sr_q[DATA_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_FULL) begin
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  sda_pull_o <= 1'b1;
                  hit_q      <= 1'b1;
                  xmit_q     <= sr_q[0];
                  if (sr_q[0]) irq_q <= 1'b1;
                  state_q    <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (full_q) begin
                // unread byte pending: refuse and keep it
                ovf_q   <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                buf_q      <= sr_q;
                full_q     <= 1'b1;
                irq_q      <= 1'b1;
                sda_pull_o <= 1'b1;
                state_q    <= ST_RX_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (xmit_q) begin
                sda_pull_o <= !sr_q[DATA_W-1];
                state_q    <= ST_TX;
              end else begin
                sda_pull_o <= 1'b0;
                state_q    <= ST_RX;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              cnt_q      <= '0;
              state_q    <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt_q == CNT_LAST) begin
                sda_pull_o <= 1'b0;
                state_q    <= ST_TX_ACK;
              end else begin
                sr_q       <= {sr_q[DATA_W-2:0], 1'b0};
                sda_pull_o <= !sr_q[DATA_W-2];
                cnt_q      <= cnt_q + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack_q <= !sda_s;
              if (!sda_s) irq_q <= 1'b1;
            end else if (scl_fall) begin
              cnt_q <= '0;
              if (mack_q) begin
                sda_pull_o <= !sr_q[DATA_W-1];
                state_q    <= ST_TX;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic [7:0] stat;
  assign stat = {gc_en_q, ovf_q, s_q, p_q, xmit_q, hit_q, full_q, irq_q};

  always_comb begin
    unique case (reg_sel_i)
      SEL_OWN:  reg_rdata_o = DATA_W'(own_q);
      SEL_MASK: reg_rdata_o = DATA_W'(mask_q);
      SEL_DATA: reg_rdata_o = buf_q;
      default:  reg_rdata_o = DATA_W'(stat);
    endcase
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/i2cs_slave_chk.sv
module i2cs_slave_chk
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              sda_pull_o,
  input state_e            state_q,
  input logic              s_q,
  input logic              p_q,
  input logic              full_q,
  input logic              ovf_q,
  input logic [DATA_W-1:0] buf_q,
  input logic              reg_we_i,
  input logic [1:0]        reg_sel_i
);
  // R11
  pull_low_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_s);

  // R2
  sp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_q && p_q));

  // R7
  buf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && !(reg_we_i && reg_sel_i == SEL_DATA) |=> $stable(buf_q));

  // R7
  ovf_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) && !$past(reg_we_i && reg_sel_i == SEL_STAT) |-> !sda_pull_o);

  // R4
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !sda_pull_o);
endmodule

bind i2cs_slave i2cs_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .sda_pull_o(sda_pull_o),
  .state_q   (state_q),
  .s_q       (s_q),
  .p_q       (p_q),
  .full_q    (full_q),
  .ovf_q     (ovf_q),
  .buf_q     (buf_q),
  .reg_we_i  (reg_we_i),
  .reg_sel_i (reg_sel_i)
);

// File: tb/i2cs_slave_test.sv
module i2cs_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [1:0] reg_sel = 2'd0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq;
  logic bus_sda;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;
  assign bus_sda = sda_m & ~sda_pull;

  i2cs_slave uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (bus_sda),
    .sda_pull_o (sda_pull),
    .reg_sel_i  (reg_sel),
    .reg_we_i   (reg_we),
    .reg_re_i   (reg_re),
    .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .irq_o      (irq)
  );

  // {own, mask, address, expected ack}
  localparam logic [21:0] VEC [8] = '{
    {7'h50, 7'h7F, 7'h50, 1'b1},
    {7'h50, 7'h7F, 7'h51, 1'b0},
    {7'h50, 7'h7E, 7'h51, 1'b1},
    {7'h50, 7'h0F, 7'h20, 1'b1},
    {7'h2A, 7'h00, 7'h7F, 1'b1},
    {7'h2A, 7'h40, 7'h6A, 1'b0},
    {7'h11, 7'h7F, 7'h00, 1'b0},
    {7'h11, 7'h7F, 7'h11, 1'b1}
  };

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic m_start;
    sda_m = 1'b1; scl_m = 1'b1; wt(10);
    sda_m = 1'b0; wt(10);
    scl_m = 1'b0; wt(10);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wt(10);
    scl_m = 1'b1; wt(10);
    sda_m = 1'b1; wt(10);
  endtask

  task automatic clk_bit(input logic d, output logic seen);
    sda_m = d; wt(10);
    scl_m = 1'b1; wt(10);
    seen = bus_sda; wt(10);
    scl_m = 1'b0; wt(10);
  endtask

  task automatic send_bits(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
  endtask

  task automatic get_ack(output logic acked);
    logic s;
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
  endtask

  // master ACK; software loads next byte while SCL is high
  task automatic ack_load(input logic [7:0] d);
    sda_m = 1'b0; wt(10);
    scl_m = 1'b1; wt(10);
    chk("R8 irq on master ack", {7'd0, irq}, 8'h01);
    host_write(2'd2, d);
    wt(8);
    scl_m = 1'b0; wt(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic a;
    wt(4);
    rst_n = 1'b1;
    wt(4);

    // R1 reset state
    peek(2'd0, v); chk("R1 own reset", v, 8'h00);
    peek(2'd1, v); chk("R1 mask reset", v, 8'h7F);
    peek(2'd2, v); chk("R1 data reset", v, 8'h00);
    peek(2'd3, v); chk("R1 status reset", v, 8'h00);
    chk("R1 pull reset", {6'd0, sda_pull, irq}, 8'h00);

    // address match table (R3, R4, R5)
    for (int k = 0; k < 8; k++) begin
      host_write(2'd0, {1'b0, VEC[k][21:15]});
      host_write(2'd1, {1'b0, VEC[k][14:8]});
      m_start;
      send_bits({VEC[k][7:1], 1'b0});
      get_ack(a);
      chk($sformatf("R3 vector %0d ack", k), {7'd0, a}, {7'd0, VEC[k][0]});
      m_stop;
    end

    host_write(2'd0, 8'h33);
    host_write(2'd1, 8'h7F);

    // R2 start/stop flags
    m_start;
    peek(2'd3, v); chk("R2 status after start", v, 8'h20);
    m_stop;
    peek(2'd3, v); chk("R2 status after stop", v, 8'h10);

    // R5 general call enabled
    host_write(2'd3, 8'h80);
    m_start;
    send_bits(8'h00);
    get_ack(a);
    chk("R5 general call ack", {7'd0, a}, 8'h01);
    m_stop;
    peek(2'd3, v); chk("R5 status gc bit", v, 8'h90);
    host_write(2'd3, 8'h00);

    // R6 receive, R7 overflow
    m_start;
    send_bits(8'h66);
    get_ack(a);
    chk("R3 write address ack", {7'd0, a}, 8'h01);
    peek(2'd3, v); chk("R3 match flag", v, 8'h24);
    send_bits(8'hA5);
    get_ack(a);
    chk("R6 data ack", {7'd0, a}, 8'h01);
    peek(2'd3, v); chk("R6 status full", v, 8'h27);
    chk("R6 irq_o", {7'd0, irq}, 8'h01);
    host_read(2'd2, v); chk("R6 data value", v, 8'hA5);
    peek(2'd3, v); chk("R6 status after read", v, 8'h24);
    chk("R6 irq_o cleared", {7'd0, irq}, 8'h00);
    send_bits(8'h3C);
    get_ack(a);
    chk("R6 second ack", {7'd0, a}, 8'h01);
    send_bits(8'hC3);
    get_ack(a);
    chk("R7 overflow nack", {7'd0, a}, 8'h00);
    peek(2'd3, v); chk("R7 overflow status", v, 8'h67);
    host_read(2'd2, v); chk("R7 buffer kept", v, 8'h3C);
    m_stop;
    peek(2'd3, v); chk("R7 status after stop", v, 8'h50);
    host_write(2'd3, 8'h00);
    peek(2'd3, v); chk("R10 overflow cleared", v, 8'h10);

    // R4 mismatch then data ignored
    m_start;
    send_bits(8'h68);
    get_ack(a);
    chk("R4 mismatch nack", {7'd0, a}, 8'h00);
    send_bits(8'h00);
    get_ack(a);
    chk("R4 data ignored", {7'd0, a}, 8'h00);
    peek(2'd3, v); chk("R4 status untouched", v, 8'h20);
    m_stop;

    // R8 transmit, R9 master nack
    m_start;
    send_bits(8'h67);
    chk("R8 irq after read address", {7'd0, irq}, 8'h01);
    peek(2'd3, v); chk("R8 status xmit", v, 8'h2D);
    host_write(2'd2, 8'hB4);
    chk("R8 irq cleared by load", {7'd0, irq}, 8'h00);
    get_ack(a);
    chk("R8 read address ack", {7'd0, a}, 8'h01);
    recv_byte(v); chk("R8 first tx byte", v, 8'hB4);
    ack_load(8'h5E);
    recv_byte(v); chk("R8 second tx byte", v, 8'h5E);
    clk_bit(1'b1, a);
    wt(5);
    chk("R9 released after nack", {7'd0, sda_pull}, 8'h00);
    clk_bit(1'b1, a);
    chk("R9 line stays high", {7'd0, a}, 8'h01);
    m_stop;

    // R10 status write mask
    host_write(2'd3, 8'hFF);
    peek(2'd3, v); chk("R10 writable bits", v, 8'hD0);
    host_write(2'd3, 8'h00);
    peek(2'd3, v); chk("R10 bits cleared", v, 8'h10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule